// File: doc/BRIEF.md
# Hashed Page Table Group Search Walker

This block translates one effective address by walking a hashed page table that sits in ordinary memory. A request brings a segment identifier, a 32-bit effective address, the access kind, the table base, the table mask and the access rights already decided by an outside key policy. The walker forms a hash from the segment identifier and the page index and reads the eight two-word entries of one 64-byte group. If none of them matches, it reads the group selected by the complemented hash. Every read and write goes through a single request/acknowledge memory port.

When an entry matches, the walker reads that entry's second word. It sets the referenced bit, and on a store also the changed bit, and writes the word back only when its value changed. It then reports the real address and the rights. On a load or fetch the rights lose write permission, so a later store comes back through the walker to set the changed bit. A search that misses in both groups reports not-found and writes nothing.

The state machine has five states. `ST_IDLE` waits for `start`. `ST_TAG` reads first words, entry by entry. `ST_DATA` reads the second word of the matching entry. `ST_WBACK` writes the updated second word. `ST_DONE` pulses `done` for one cycle.

The transitions are:
- idle→tag on `start`.
- tag→tag on a non-matching acknowledge. This advances the entry, and after the eighth primary entry it switches to the secondary pass.
- tag→data on a match.
- tag→done after the eighth secondary entry misses.
- data→wback when the second word changed.
- data→done when it did not.
- wback→done on acknowledge.
- done→idle always.

Top module: `hpt_walker`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and `mem_we` are low. `start` is only accepted while `busy` is low.
- R2: The page index is `ea[27:12]`. The compare word is `{1'b0, vsid[23:0], 1'b0, pgidx[15:10]}`. An entry's first word matches when its bits 30:7 and 5:0 equal the compare word's bits in the same positions.
- R3: The primary hash is `vsid[18:0] ^ {3'b0, pgidx}`. The group address is `base | ((hash << 6) & mask)`. Entry k has its first word at group+8k and its second word at group+8k+4. Entries are read in ascending k.
- R4: Within a group, the first matching entry in scan order wins and no later entry is read.
- R5: An entry matches only if first-word bit 31 (valid) is 1 and bit 6 (secondary flag) equals the pass: 0 on the primary pass, 1 on the secondary pass.
- R6: The secondary group is read only after all 8 primary entries miss. Its hash is the 19-bit complement of the primary hash.
- R7: On a hit, `raddr` is `{w1[31:12], ea[11:0]}`, where w1 is the second word of the matching entry.
- R8: On a hit, the second word gets bit 8 (referenced) set, and bit 7 (changed) also set when `acc` is store (2'd1). It is written back only if this changes its value.
- R9: `prot_out` equals `prot_in`, except that bit 1 (write) is cleared unless `acc` is store. `prot_in` bit 0 is read and bit 2 is execute. `acc` encodes load as 0, store as 1 and fetch as 2.
- R10: When both groups miss, `done` pulses with `found` low after exactly 16 first-word reads and no write.
- R11: `mem_req` stays high with a stable address, write enable and write data until `mem_ack` arrives. `done` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (accepted when idle) |
| vsid | input | 24 | Segment virtual identifier |
| ea | input | 32 | Effective address |
| acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| base | input | 32 | Table base address |
| mask | input | 32 | Table offset mask |
| prot_in | input | 3 | Rights from key policy: bit0 read, bit1 write, bit2 execute |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Entry found (valid with and after done) |
| raddr | output | 32 | Real address |
| prot_out | output | 3 | Returned rights |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle per request |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The assertions assume that the memory raises `mem_ack` only while `mem_req` is high, for a single cycle per access, with read data valid in that cycle. They also assume that `base` has its low six bits clear and does not overlap `mask`. The bench memory answers only pending requests, after a rotating latency of zero to two idle cycles. It drops its acknowledge on the following cycle. Every table base and mask it uses is group aligned and disjoint.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAG,
        ST_DATA,
        ST_WBACK,
        ST_DONE
    } walk_st_e;

    localparam int W0_VALID_BIT = 31;
    localparam int W0_HSEL_BIT  = 6;
    localparam int W1_REF_BIT   = 8;
    localparam int W1_CHG_BIT   = 7;
    localparam int PROT_WR_BIT  = 1;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
    parameter int VSID_W      = 24,
    parameter int PGIDX_W     = 16,
    parameter int HASH_W      = 19,
    parameter int GROUP_SHIFT = 6,
    parameter int ADDR_W      = 32,
    parameter int API_W       = 6
) (
    input  logic [VSID_W-1:0]  vsid,
    input  logic [PGIDX_W-1:0] pgidx,
    input  logic [ADDR_W-1:0]  base,
    input  logic [ADDR_W-1:0]  mask,
    input  logic               second,
    output logic [ADDR_W-1:0]  grp_addr,
    output logic [31:0]        cmp_word
);
    localparam int PAD_W = ADDR_W - HASH_W - GROUP_SHIFT;

    logic [HASH_W-1:0] h_pri;
    logic [HASH_W-1:0] h_sel;
    logic [ADDR_W-1:0] offs;

    always_comb begin
        h_pri    = vsid[HASH_W-1:0] ^ {{(HASH_W-PGIDX_W){1'b0}}, pgidx};
        h_sel    = second ? ~h_pri : h_pri;
        offs     = {{PAD_W{1'b0}}, h_sel, {GROUP_SHIFT{1'b0}}} & mask;
        grp_addr = base | offs;
        cmp_word = {1'b0, vsid, 1'b0, pgidx[PGIDX_W-1 -: API_W]};
    end
endmodule

// File: rtl/hpt_match.sv
module hpt_match (
    input  logic [31:0] word0,
    input  logic [31:0] cmp_word,
    input  logic        second,
    output logic        hit
);
    import hpt_pkg::*;
    localparam logic [31:0] CMP_MASK = 32'h7FFF_FFBF;

    always_comb begin
        hit = word0[W0_VALID_BIT]
            && (word0[W0_HSEL_BIT] == second)
            && ((word0 & CMP_MASK) == cmp_word);
    end
endmodule

// File: rtl/hpt_rc.sv
module hpt_rc #(
    parameter int PAGE_BITS = 12
) (
    input  logic [31:0]          word1,
    input  logic                 is_store,
    input  logic [2:0]           prot_in,
    input  logic [PAGE_BITS-1:0] page_off,
    output logic [31:0]          new_word1,
    output logic                 changed,
    output logic [2:0]           prot_out,
    output logic [31:0]          raddr
);
    import hpt_pkg::*;

    always_comb begin
        new_word1 = word1;
        new_word1[W1_REF_BIT] = 1'b1;
        if (is_store) new_word1[W1_CHG_BIT] = 1'b1;
        changed  = (new_word1 != word1);
        prot_out = prot_in;
        if (!is_store) prot_out[PROT_WR_BIT] = 1'b0;
        raddr    = {word1[31:PAGE_BITS], page_off};
    end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker #(
    parameter int VSID_W      = 24,
    parameter int ADDR_W      = 32,
    parameter int ENTRIES     = 8,
    parameter int ENTRY_BYTES = 8,
    parameter int GROUP_SHIFT = 6,
    parameter int HASH_W      = 19,
    parameter int PAGE_BITS   = 12,
    parameter int PGIDX_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VSID_W-1:0] vsid,
    input  logic [31:0]       ea,
    input  logic [1:0]        acc,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] mask,
    input  logic [2:0]        prot_in,
    output logic              busy,
    output logic              done,
    output logic              found,
    output logic [31:0]       raddr,
    output logic [2:0]        prot_out,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata
);
    import hpt_pkg::*;

    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int ESHIFT  = $clog2(ENTRY_BYTES);
    localparam int W1_OFFS = ENTRY_BYTES / 2;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    walk_st_e             state, nstate;
    logic [IDX_W-1:0]     idx_q;
    logic                 second_q;
    logic [VSID_W-1:0]    vsid_q;
    logic [PGIDX_W-1:0]   pg_q;
    logic [PAGE_BITS-1:0] poff_q;
    logic                 store_q;
    logic [ADDR_W-1:0]    base_q, mask_q;
    logic [2:0]           prot_in_q;
    logic [31:0]          wb_q;

    logic [ADDR_W-1:0]    grp_addr, ent_addr;
    logic [31:0]          cmp_word;
    logic                 tag_hit;
    logic [31:0]          rc_word;
    logic                 rc_changed;
    logic [2:0]           rc_prot;
    logic [31:0]          rc_raddr;

    hpt_hash #(
        .VSID_W(VSID_W), .PGIDX_W(PGIDX_W), .HASH_W(HASH_W),
        .GROUP_SHIFT(GROUP_SHIFT), .ADDR_W(ADDR_W), .API_W(6)
    ) u_hash (
        .vsid(vsid_q), .pgidx(pg_q), .base(base_q), .mask(mask_q),
        .second(second_q), .grp_addr(grp_addr), .cmp_word(cmp_word)
    );

    hpt_match u_match (
        .word0(mem_rdata), .cmp_word(cmp_word), .second(second_q), .hit(tag_hit)
    );

    hpt_rc #(.PAGE_BITS(PAGE_BITS)) u_rc (
        .word1(mem_rdata), .is_store(store_q), .prot_in(prot_in_q),
        .page_off(poff_q), .new_word1(rc_word), .changed(rc_changed),
        .prot_out(rc_prot), .raddr(rc_raddr)
    );

    assign ent_addr = grp_addr + {{(ADDR_W-IDX_W-ESHIFT){1'b0}}, idx_q, {ESHIFT{1'b0}}};

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (start) nstate = ST_TAG;
            ST_TAG: begin
                if (mem_ack) begin
                    if (tag_hit)                             nstate = ST_DATA;
                    else if (idx_q == LAST_IDX && second_q)  nstate = ST_DONE;
                end
            end
            ST_DATA:  if (mem_ack) nstate = rc_changed ? ST_WBACK : ST_DONE;
            ST_WBACK: if (mem_ack) nstate = ST_DONE;
            ST_DONE:  nstate = ST_IDLE;
            default:  nstate = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            idx_q     <= '0;
            second_q  <= 1'b0;
            vsid_q    <= '0;
            pg_q      <= '0;
            poff_q    <= '0;
            store_q   <= 1'b0;
            base_q    <= '0;
            mask_q    <= '0;
            prot_in_q <= '0;
            wb_q      <= '0;
            found     <= 1'b0;
            raddr     <= '0;
            prot_out  <= '0;
        end else begin
            state <= nstate;
            unique case (state)
                ST_IDLE: if (start) begin
                    idx_q     <= '0;
                    second_q  <= 1'b0;
                    vsid_q    <= vsid;
                    pg_q      <= ea[PAGE_BITS+PGIDX_W-1:PAGE_BITS];
                    poff_q    <= ea[PAGE_BITS-1:0];
                    store_q   <= (acc == ACC_STORE);
                    base_q    <= base;
                    mask_q    <= mask;
                    prot_in_q <= prot_in;
                    found     <= 1'b0;
                end
                ST_TAG: if (mem_ack && !tag_hit) begin
                    if (idx_q == LAST_IDX) begin
                        idx_q    <= '0;
                        second_q <= 1'b1;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_DATA: if (mem_ack) begin
                    wb_q     <= rc_word;
                    raddr    <= rc_raddr;
                    prot_out <= rc_prot;
                    found    <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        done      = 1'b0;
        busy      = (state != ST_IDLE);
        unique case (state)
            ST_IDLE: ;
            ST_TAG: begin
                mem_req  = 1'b1;
                mem_addr = ent_addr;
            end
            ST_DATA: begin
                mem_req  = 1'b1;
                mem_addr = ent_addr + ADDR_W'(W1_OFFS);
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ent_addr + ADDR_W'(W1_OFFS);
                mem_wdata = wb_q;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    in_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((mem_addr & ~(mask_q | ADDR_W'((1 << GROUP_SHIFT) - 1)))
                     == (base_q & ~(mask_q | ADDR_W'((1 << GROUP_SHIFT) - 1)))));

    // R8
    wb_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_wdata[W1_REF_BIT]);

    // R9
    no_wr_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found && !store_q) |-> !prot_out[PROT_WR_BIT]);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !done));
endmodule

// File: tb/sim_hpt_walker.sv
`timescale 1ns/1ps
module sim_hpt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] vsid = '0;
    logic [31:0] ea = '0;
    logic [1:0]  acc = '0;
    logic [31:0] base = 32'h0010_0000;
    logic [31:0] mask = 32'h0000_3FC0;
    logic [2:0]  prot_in = '0;
    logic        busy, done, found;
    logic [31:0] raddr;
    logic [2:0]  prot_out;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    hpt_walker u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .vsid(vsid), .ea(ea), .acc(acc),
        .base(base), .mask(mask), .prot_in(prot_in), .busy(busy), .done(done),
        .found(found), .raddr(raddr), .prot_out(prot_out), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0] mem [logic [31:0]];
    logic [31:0] exp_addr [$];
    bit          exp_we [$];
    logic [31:0] exp_wd [$];
    bit          exp_found;
    logic [31:0] exp_raddr;
    logic [2:0]  exp_prot;

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] grp(input logic [23:0] v, input logic [31:0] e, input bit sec);
        int unsigned h;
        h = (v & 24'h07FFFF) ^ ((e >> 12) & 32'hFFFF);
        if (sec) h = (~h) & 32'h7FFFF;
        return base | ((h * 64) & mask);
    endfunction

    function automatic logic [31:0] w0_of(input bit valid, input bit hs, input logic [23:0] v, input logic [5:0] api);
        return {valid, v, hs, api};
    endfunction

    task automatic put(input bit sec, input int slot, input logic [31:0] w0, input logic [31:0] w1,
                       input logic [23:0] v, input logic [31:0] e);
        logic [31:0] a;
        a = grp(v, e, sec) + slot * 8;
        mem[a] = w0;
        mem[a + 4] = w1;
    endtask

    // reference model: builds the access sequence and result
    task automatic model(input logic [23:0] v, input logic [31:0] e, input logic [1:0] ac, input logic [2:0] pr);
        logic [31:0] cw, a, w0, w1, nw;
        bit hit;
        exp_addr.delete(); exp_we.delete(); exp_wd.delete();
        exp_found = 0;
        cw = (32'(v) << 7) | ((e >> 22) & 32'h3F);
        hit = 0;
        for (int p = 0; p < 2 && !hit; p++) begin
            for (int k = 0; k < 8 && !hit; k++) begin
                a = grp(v, e, p[0]) + k * 8;
                w0 = rd(a);
                exp_addr.push_back(a); exp_we.push_back(0); exp_wd.push_back(0);
                if (w0[31] && (w0[6] == p[0]) && ((w0 & 32'h7FFF_FFBF) == cw)) begin
                    hit = 1;
                    w1 = rd(a + 4);
                    exp_addr.push_back(a + 4); exp_we.push_back(0); exp_wd.push_back(0);
                    nw = w1 | 32'h100 | ((ac == 2'd1) ? 32'h80 : 32'h0);
                    if (nw != w1) begin
                        exp_addr.push_back(a + 4); exp_we.push_back(1); exp_wd.push_back(nw);
                    end
                    exp_found = 1;
                    exp_raddr = {w1[31:12], e[11:0]};
                    exp_prot  = (ac == 2'd1) ? pr : (pr & 3'b101);
                end
            end
        end
    endtask

    // memory responder
    int lat = 0;
    int waitc = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (waitc >= lat) begin
                mem_ack   <= 1'b1;
                mem_rdata <= rd(mem_addr);
                waitc     <= 0;
                lat       <= (lat + 1) % 3;
            end else begin
                waitc <= waitc + 1;
            end
        end
    end

    // per-clock comparison against the reference access sequence
    logic [31:0] prev_addr = '0;
    bit          prev_pend = 0;
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (prev_pend) chk(mem_req && mem_addr == prev_addr, "R11 request held", mem_addr, prev_addr);
            prev_pend = mem_req && !mem_ack;
            prev_addr = mem_addr;
            if (mem_req && mem_ack) begin
                if (exp_addr.size() == 0) begin
                    chk(0, "R10/R4 unexpected access", mem_addr, 32'h0);
                end else begin
                    chk(mem_addr == exp_addr[0], "R3/R6 access address", mem_addr, exp_addr[0]);
                    chk(mem_we == exp_we[0], "R8 write enable", 32'(mem_we), 32'(exp_we[0]));
                    if (exp_we[0]) chk(mem_wdata == exp_wd[0], "R8 write data", mem_wdata, exp_wd[0]);
                    void'(exp_addr.pop_front()); void'(exp_we.pop_front()); void'(exp_wd.pop_front());
                end
                if (mem_we) mem[mem_addr] = mem_wdata;
            end
        end
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic walk(input logic [23:0] v, input logic [31:0] e, input logic [1:0] ac,
                        input logic [2:0] pr, input string tag);
        model(v, e, ac, pr);
        @(negedge clk);
        vsid = v; ea = e; acc = ac; prot_in = pr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        chk(found == exp_found, {tag, " found"}, 32'(found), 32'(exp_found));
        if (exp_found) begin
            chk(raddr == exp_raddr, {tag, " R7 raddr"}, raddr, exp_raddr);
            chk(prot_out == exp_prot, {tag, " R9 prot"}, 32'(prot_out), 32'(exp_prot));
        end
        chk(exp_addr.size() == 0, {tag, " access count"}, exp_addr.size(), 0);
        @(negedge clk);
        chk(!done && !busy, {tag, " R11 done one cycle"}, 32'(done), 0);
    endtask

    logic [23:0] va;
    logic [31:0] ea_a;
    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_req && !mem_we, "R1 reset state", {28'h0, busy, done, mem_req, mem_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req, "R1 idle after reset", {30'h0, busy, mem_req}, 0);

        // R2 R3 R7 R8 R9: primary hit at slot 3, load
        va = 24'h12_3456; ea_a = 32'h5ABC_D123;
        put(0, 0, w0_of(1, 0, va ^ 24'h1, ea_a[27:22]), 32'hDEAD_0000, va, ea_a);
        put(0, 1, w0_of(1, 0, va, ea_a[27:22] ^ 6'h1), 32'hBEEF_0000, va, ea_a);
        put(0, 3, w0_of(1, 0, va, ea_a[27:22]), 32'hCAFE_5002, va, ea_a);
        walk(va, ea_a, 2'd0, 3'b111, "R2 primary load");
        chk(rd(grp(va, ea_a, 0) + 28) == 32'hCAFE_5102, "R8 referenced in memory",
            rd(grp(va, ea_a, 0) + 28), 32'hCAFE_5102);
        // R8: repeat load, no write expected
        walk(va, ea_a, 2'd0, 3'b011, "R8 no rewrite");
        // R8 R9: store sets changed, keeps write right
        walk(va, ea_a, 2'd1, 3'b011, "R9 store");
        chk(rd(grp(va, ea_a, 0) + 28) == 32'hCAFE_5182, "R8 changed in memory",
            rd(grp(va, ea_a, 0) + 28), 32'hCAFE_5182);

        // R4: two matches in primary, slot 1 wins
        va = 24'hA0_0F00; ea_a = 32'h1234_5678;
        put(0, 1, w0_of(1, 0, va, ea_a[27:22]), 32'h1111_1180, va, ea_a);
        put(0, 5, w0_of(1, 0, va, ea_a[27:22]), 32'h2222_2000, va, ea_a);
        walk(va, ea_a, 2'd2, 3'b110, "R4 first match");

        // R5 R6: invalid and wrong-pass entries skipped, secondary hit
        va = 24'h03_7777; ea_a = 32'h7FED_C000;
        put(0, 2, w0_of(0, 0, va, ea_a[27:22]), 32'h3333_3000, va, ea_a);
        put(0, 4, w0_of(1, 1, va, ea_a[27:22]), 32'h4444_4000, va, ea_a);
        put(1, 0, w0_of(1, 0, va, ea_a[27:22]), 32'h5555_5000, va, ea_a);
        put(1, 6, w0_of(1, 1, va, ea_a[27:22]), 32'h6666_6000, va, ea_a);
        walk(va, ea_a, 2'd1, 3'b111, "R5 R6 secondary");

        // R10: miss in both groups
        va = 24'hFF_0001; ea_a = 32'h0000_1000;
        put(0, 7, w0_of(1, 0, va, ea_a[27:22] ^ 6'h3), 32'h7777_7000, va, ea_a);
        walk(va, ea_a, 2'd0, 3'b111, "R10 miss");

        // R1: start while busy is ignored (second start does not restart)
        va = 24'h12_3456; ea_a = 32'h5ABC_D123;
        model(va, ea_a, 2'd2, 3'b101);
        @(negedge clk);
        vsid = va; ea = ea_a; acc = 2'd2; prot_in = 3'b101; start = 1'b1;
        @(negedge clk);
        vsid = 24'h0; ea = 32'h0;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        chk(found && raddr == exp_raddr, "R1 start ignored while busy", raddr, exp_raddr);
        chk(exp_addr.size() == 0, "R1 no extra accesses", exp_addr.size(), 0);
        @(negedge clk);
        @(negedge clk);
        chk(!busy, "R1 stays idle", 32'(busy), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule